// File: doc/BRIEF.md
# Programmable Slow-Port Cycle Timing Generator

This block times single accesses to an asynchronous boot memory or a slow peripheral on an external memory bus. A caller presents an address, a read/write flag, write data and a space select. The block then runs one access cycle whose length comes from a down-counter. The counter is loaded from one of two cycle-count settings: one for the boot space and one for the peripheral space. The counter's least significant bit is always forced to 1.

Four threshold settings place the strobe edges inside the cycle. Each edge sits a fixed number of cycles after the access starts, and that number is derived from the loaded count. Two thresholds bound the active window of the read or write strobe. The other two bound the device enable.

For boot-space accesses, two address bits pick one active-low chip select. A direction output tells an external buffer which way the data flows. Read data is captured when the read strobe releases. An optional active-low ready input can hold the cycle with the strobe still active. When ready mode is off, the ready pin's partner output serves as a high-byte enable instead.

Top module: `slowport_timing_gen`

## Requirements
- R1: An accepted boot-space request loads the counter with C = boot count with bit 0 forced to 1; `busy` is high for exactly C+1 cycles, starting on the edge that accepts the request.
- R2: An even programmed count produces the same cycle as that count plus one. For example, 0x22 behaves exactly like 0x23.
- R3: A peripheral-space request (`req_slow`=1) takes its cycle length C from the peripheral count, with the same forced bit 0.
- R4: The strobe of the access goes low (BCC − ON + 1) cycles after the accepting edge and high again (BCC − OFF + 1) cycles after it. Here ON is `cfg_rw_on`, OFF is `cfg_rw_off`, and BCC stands for C.
- R5: `dev_en_n` is low from (C − `cfg_en_on` + 1) cycles after the accepting edge until (C − `cfg_en_off` + 1) cycles after it.
- R6: A read (`req_write`=0) pulses only `rd_n`, and a write pulses only `wr_n`; the other strobe stays high. `dir` is 1 for a read and 0 for a write, stays constant while `busy`, and is 1 when idle.
- R7: For the boot space, `cs_n` is low only on bit `req_addr[20:19]` (00→1110, 01→1101, 10→1011, 11→0111) for the whole access. For the peripheral space, and when idle, `cs_n` is 1111.
- R8: With `cfg_rdy_en`=1, the counter stops at the value `cfg_rw_off` while `rdy_n` is high, with the strobe held low. Each such cycle lengthens the access by one.
- R9: With `cfg_rdy_en`=0, `hi_en_n` follows `dev_en_n`. With `cfg_rdy_en`=1, `hi_en_n` stays high.
- R10: A read captures `bus_rdata_in` on the edge where `rd_n` returns high; `rdata` holds it and `rdata_valid` pulses for one cycle.
- R11: A request is accepted only when `busy` is low. A request made during an access changes none of its outputs or its length.
- R12: After reset, `busy` and `rdata_valid` are 0 and all active-low strobes and chip selects are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_slow | input | 1 | 1 = peripheral space, 0 = boot space |
| req_addr | input | ADDR_W (21) | Internal byte address |
| req_wdata | input | DATA_W (32) | Write data |
| cfg_boot_cnt | input | CNT_W (8) | Boot-space cycle count |
| cfg_slow_cnt | input | CNT_W (8) | Peripheral-space cycle count |
| cfg_rw_on | input | CNT_W (8) | Strobe assert threshold |
| cfg_rw_off | input | CNT_W (8) | Strobe release threshold, also ready hold point |
| cfg_en_on | input | CNT_W (8) | Device enable assert threshold |
| cfg_en_off | input | CNT_W (8) | Device enable release threshold |
| cfg_rdy_en | input | 1 | Ready mode enable |
| rdy_n | input | 1 | Active-low ready |
| bus_rdata_in | input | DATA_W (32) | Data from the external bus |
| busy | output | 1 | Access in progress |
| dev_en_n | output | 1 | Active-low device enable |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| cs_n | output | 4 | Active-low chip selects |
| dir | output | 1 | Buffer direction, 1 = read |
| hi_en_n | output | 1 | High-byte enable when ready mode is off |
| bus_addr | output | ADDR_W (21) | Latched access address |
| bus_wdata | output | DATA_W (32) | Latched write data |
| rdata | output | DATA_W (32) | Captured read data |
| rdata_valid | output | 1 | One-cycle pulse when rdata is updated |

## Verification
Every output is compared against a counter model on every cycle of each access, so an edge placed one cycle early or late is caught. Such an error typically comes from comparing the threshold with `<=` instead of `<`.

An even count setting checks that bit 0 is forced. Without the forcing, the access would end one cycle sooner.

The bus read data changes value right after the release edge. A capture taken one edge late would therefore return the wrong word.

A ready stall of several cycles checks that the counter freezes at the release threshold with the strobe held low. A design that froze anywhere else would shift the enable edges.

A request made in the middle of an access checks that the address, selects and length stay as they were.

// File: rtl/sp_timing_pkg.sv
package sp_timing_pkg;
    localparam int CNT_W_DEF = 8;
    typedef enum logic {SPACE_BOOT = 1'b0, SPACE_PERIPH = 1'b1} space_e;
endpackage

// File: rtl/sp_down_counter.sv
module sp_down_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         stall,
    output logic [W-1:0] cnt_d,
    output logic         run_d,
    output logic [W-1:0] cnt_q,
    output logic         run_q
);
    always_comb begin
        cnt_d = cnt_q;
        run_d = run_q;
        if (load) begin
            cnt_d = {load_val[W-1:1], 1'b1};
            run_d = 1'b1;
        end else if (run_q && !stall) begin
            if (cnt_q == '0) run_d = 1'b0;
            else             cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            run_q <= run_d;
        end
    end

    // R2: every cycle starts from an odd count
    p_odd_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run_q && !$past(run_q) |-> cnt_q[0]);

    // R8: a stalled counter keeps its value and keeps running
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        run_q && stall && !load |=> run_q && cnt_q == $past(cnt_q));
endmodule

// File: rtl/sp_window.sv
module sp_window #(
    parameter int W = 8
) (
    input  logic         active,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] on_th,
    input  logic [W-1:0] off_th,
    output logic         hit
);
    always_comb hit = active && (cnt < on_th) && (cnt >= off_th);
endmodule

// File: rtl/sp_cs_decode.sv
module sp_cs_decode #(
    parameter int SEL_W = 2,
    localparam int CS_N = 1 << SEL_W
) (
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic [CS_N-1:0]  cs_n
);
    for (genvar i = 0; i < CS_N; i++) begin : g_cs
        assign cs_n[i] = !(en && sel == SEL_W'(i));
    end
endmodule

// File: rtl/slowport_timing_gen.sv
module slowport_timing_gen #(
    parameter int ADDR_W     = 21,
    parameter int DATA_W     = 32,
    parameter int CNT_W      = sp_timing_pkg::CNT_W_DEF,
    parameter int CS_SEL_LSB = 19,
    parameter int CS_SEL_W   = 2,
    localparam int CS_N      = 1 << CS_SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_slow,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [CNT_W-1:0]  cfg_boot_cnt,
    input  logic [CNT_W-1:0]  cfg_slow_cnt,
    input  logic [CNT_W-1:0]  cfg_rw_on,
    input  logic [CNT_W-1:0]  cfg_rw_off,
    input  logic [CNT_W-1:0]  cfg_en_on,
    input  logic [CNT_W-1:0]  cfg_en_off,
    input  logic              cfg_rdy_en,
    input  logic              rdy_n,
    input  logic [DATA_W-1:0] bus_rdata_in,
    output logic              busy,
    output logic              dev_en_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [CS_N-1:0]   cs_n,
    output logic              dir,
    output logic              hi_en_n,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_valid
);
    import sp_timing_pkg::*;

    typedef struct packed {
        logic              busy;
        logic              write;
        space_e            space;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              dev_en_n;
        logic              rd_n;
        logic              wr_n;
        logic [CS_N-1:0]   cs_n;
        logic              dir;
        logic              hi_en_n;
        logic [DATA_W-1:0] rdata;
        logic              rdata_valid;
    } state_t;

    state_t st_d, st_q;

    logic              accept, stall, capture;
    logic [CNT_W-1:0]  load_val, cnt_d, cnt_q;
    logic              run_d, run_q;
    logic              nxt_write;
    space_e            nxt_space;
    logic [ADDR_W-1:0] nxt_addr;
    logic              rw_hit, en_hit;
    logic [CS_N-1:0]   cs_dec_n;

    assign accept    = req_valid && !st_q.busy;
    assign load_val  = req_slow ? cfg_slow_cnt : cfg_boot_cnt;
    assign stall     = cfg_rdy_en && rdy_n && run_q && (cnt_q == cfg_rw_off);
    assign capture   = run_q && !stall && (cnt_q == cfg_rw_off) && !st_q.write;
    assign nxt_write = accept ? req_write : st_q.write;
    assign nxt_space = accept ? space_e'(req_slow) : st_q.space;
    assign nxt_addr  = accept ? req_addr : st_q.addr;

    sp_down_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (load_val),
        .stall    (stall),
        .cnt_d    (cnt_d),
        .run_d    (run_d),
        .cnt_q    (cnt_q),
        .run_q    (run_q)
    );

    sp_window #(.W(CNT_W)) u_rw_win (
        .active (run_d),
        .cnt    (cnt_d),
        .on_th  (cfg_rw_on),
        .off_th (cfg_rw_off),
        .hit    (rw_hit)
    );

    sp_window #(.W(CNT_W)) u_en_win (
        .active (run_d),
        .cnt    (cnt_d),
        .on_th  (cfg_en_on),
        .off_th (cfg_en_off),
        .hit    (en_hit)
    );

    sp_cs_decode #(.SEL_W(CS_SEL_W)) u_cs (
        .en   (run_d && nxt_space == SPACE_BOOT),
        .sel  (nxt_addr[CS_SEL_LSB +: CS_SEL_W]),
        .cs_n (cs_dec_n)
    );

    always_comb begin
        st_d             = st_q;
        st_d.busy        = run_d;
        st_d.write       = nxt_write;
        st_d.space       = nxt_space;
        st_d.addr        = nxt_addr;
        if (accept) st_d.wdata = req_wdata;
        st_d.rd_n        = !(rw_hit && !nxt_write);
        st_d.wr_n        = !(rw_hit && nxt_write);
        st_d.dev_en_n    = !en_hit;
        st_d.hi_en_n     = !(en_hit && !cfg_rdy_en);
        st_d.cs_n        = cs_dec_n;
        st_d.dir         = run_d ? !nxt_write : 1'b1;
        st_d.rdata_valid = capture;
        if (capture) st_d.rdata = bus_rdata_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.dev_en_n <= 1'b1;
            st_q.rd_n     <= 1'b1;
            st_q.wr_n     <= 1'b1;
            st_q.cs_n     <= '1;
            st_q.dir      <= 1'b1;
            st_q.hi_en_n  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy        = st_q.busy;
    assign dev_en_n    = st_q.dev_en_n;
    assign rd_n        = st_q.rd_n;
    assign wr_n        = st_q.wr_n;
    assign cs_n        = st_q.cs_n;
    assign dir         = st_q.dir;
    assign hi_en_n     = st_q.hi_en_n;
    assign bus_addr    = st_q.addr;
    assign bus_wdata   = st_q.wdata;
    assign rdata       = st_q.rdata;
    assign rdata_valid = st_q.rdata_valid;

    p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n || wr_n);

    p_dir_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(dir));

    p_cs_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    p_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |-> $past(!rd_n) && rd_n);

    p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(bus_addr) && $stable(cs_n));

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> rd_n && wr_n && dev_en_n && (&cs_n));
endmodule

// File: tb/slowport_timing_gen_test.sv
module slowport_timing_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_slow = 1'b0;
    logic [20:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [7:0]  cfg_boot_cnt = 8'h23, cfg_slow_cnt = 8'h41;
    logic [7:0]  cfg_rw_on = 8'h1C, cfg_rw_off = 8'h09;
    logic [7:0]  cfg_en_on = 8'h20, cfg_en_off = 8'h04;
    logic        cfg_rdy_en = 1'b0, rdy_n = 1'b0;
    logic [31:0] bus_rdata_in = '0;
    logic        busy, dev_en_n, rd_n, wr_n, dir, hi_en_n, rdata_valid;
    logic [3:0]  cs_n;
    logic [20:0] bus_addr;
    logic [31:0] bus_wdata, rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    slowport_timing_gen uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_slow(req_slow), .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_boot_cnt(cfg_boot_cnt), .cfg_slow_cnt(cfg_slow_cnt),
        .cfg_rw_on(cfg_rw_on), .cfg_rw_off(cfg_rw_off),
        .cfg_en_on(cfg_en_on), .cfg_en_off(cfg_en_off),
        .cfg_rdy_en(cfg_rdy_en), .rdy_n(rdy_n), .bus_rdata_in(bus_rdata_in),
        .busy(busy), .dev_en_n(dev_en_n), .rd_n(rd_n), .wr_n(wr_n),
        .cs_n(cs_n), .dir(dir), .hi_en_n(hi_en_n), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .rdata(rdata), .rdata_valid(rdata_valid)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int cnt_at(int k, int c, int k0, int s, int d);
        if (k <= k0)     return c - k;
        if (k <= k0 + s) return d;
        return d - (k - k0 - s);
    endfunction

    // Runs one access and compares every output on every cycle against the model
    task automatic run_access(input string tag, input logic wr, input logic sl,
                              input logic [20:0] addr, input logic [31:0] data,
                              input int stall, input bit poke);
        int c, k0, last, a, d, ea, ed;
        c  = int'((sl ? cfg_slow_cnt : cfg_boot_cnt) | 8'h01);
        a  = int'(cfg_rw_on);  d  = int'(cfg_rw_off);
        ea = int'(cfg_en_on);  ed = int'(cfg_en_off);
        k0 = c - d;
        last = c + stall;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_slow = sl;
        req_addr = addr; req_wdata = data; bus_rdata_in = data;
        rdy_n = cfg_rdy_en ? 1'b1 : 1'b0;
        @(posedge clk);
        for (int k = 0; k <= last + 1; k++) begin
            logic bz, rw_on, en_on, rv;
            logic [3:0] cs_e;
            logic [10:0] exp_v;
            int cv;
            @(negedge clk);
            if (k == 0) req_valid = 1'b0;
            cv    = cnt_at(k, c, k0, stall, d);
            bz    = (k <= last);
            rw_on = bz && cv < a && cv >= d;
            en_on = bz && cv < ea && cv >= ed;
            rv    = !wr && (k == k0 + stall + 1);
            cs_e  = (bz && !sl) ? ~(4'b0001 << addr[20:19]) : 4'hF;
            exp_v = {bz, !en_on, !(rw_on && !wr), !(rw_on && wr), cs_e,
                     bz ? !wr : 1'b1, !(en_on && !cfg_rdy_en), rv};
            // R1 R3 R4 R5 R6 R7 R8 R9 R10 cycle-exact output vector
            check({tag, " R1 R4 R5 R6 R7 R9 outputs k=", $sformatf("%0d", k)},
                  32'({busy, dev_en_n, rd_n, wr_n, cs_n, dir, hi_en_n, rdata_valid}),
                  32'(exp_v));
            if (bz) begin
                check({tag, " R11 address held"}, 32'(bus_addr), 32'(addr));
                if (wr) check({tag, " R6 write data"}, bus_wdata, data);
            end
            if (rv) check({tag, " R10 captured data"}, rdata, data);
            rdy_n = (cfg_rdy_en && (k + 1 <= k0 + stall)) ? 1'b1 : 1'b0;
            bus_rdata_in = (k + 1 <= k0 + stall + 1) ? data : ~data;
            if (poke && k == 1) begin
                req_valid = 1'b1; req_write = !wr;
                req_addr = addr ^ 21'h080000; req_slow = !sl;
            end
            if (poke && k == 2) req_valid = 1'b0;
        end
    endtask

    task automatic t_reset;
        check("R12 reset state", 32'({busy, dev_en_n, rd_n, wr_n, cs_n, dir, hi_en_n, rdata_valid}),
              32'({1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 1'b1, 1'b1, 1'b0}));
    endtask

    task automatic t_boot_read;
        run_access("R1 boot read cs0", 1'b0, 1'b0, 21'h012345, 32'hA5C3_1E77, 0, 0);
        run_access("R7 boot read cs3", 1'b0, 1'b0, 21'h1C0010, 32'h0BAD_F00D, 0, 0);
    endtask

    task automatic t_boot_write;
        run_access("R6 boot write cs1", 1'b1, 1'b0, 21'h080004, 32'h1234_5678, 0, 0);
        run_access("R7 boot write cs2", 1'b1, 1'b0, 21'h100008, 32'hCAFE_0001, 0, 0);
    endtask

    task automatic t_even_count;
        cfg_boot_cnt = 8'h22;
        run_access("R2 even count", 1'b0, 1'b0, 21'h000100, 32'h5555_AAAA, 0, 0);
        cfg_boot_cnt = 8'h06; cfg_rw_on = 8'h06; cfg_rw_off = 8'h01;
        cfg_en_on = 8'h07; cfg_en_off = 8'h00;
        run_access("R2 short cycle", 1'b0, 1'b0, 21'h0C0000, 32'h7777_0000, 0, 0);
        run_access("R4 short write", 1'b1, 1'b0, 21'h040000, 32'h0000_7777, 0, 0);
        cfg_boot_cnt = 8'h23; cfg_rw_on = 8'h1C; cfg_rw_off = 8'h09;
        cfg_en_on = 8'h20; cfg_en_off = 8'h04;
    endtask

    task automatic t_slow_space;
        run_access("R3 periph read", 1'b0, 1'b1, 21'h1FFFFF, 32'h0F0F_F0F0, 0, 0);
        cfg_slow_cnt = 8'h10;
        run_access("R3 periph even write", 1'b1, 1'b1, 21'h000002, 32'h3C3C_3C3C, 0, 0);
        cfg_slow_cnt = 8'h41;
    endtask

    task automatic t_ready_stall;
        cfg_rdy_en = 1'b1;
        run_access("R8 ready stall read", 1'b0, 1'b0, 21'h090000, 32'hDEAD_BEEF, 5, 0);
        run_access("R8 ready no stall", 1'b1, 1'b0, 21'h110000, 32'hBEEF_DEAD, 0, 0);
        run_access("R9 ready stall write", 1'b1, 1'b1, 21'h000040, 32'h2468_ACE0, 3, 0);
        cfg_rdy_en = 1'b0;
    endtask

    task automatic t_busy_ignore;
        run_access("R11 request while busy", 1'b0, 1'b0, 21'h0A0000, 32'h1357_9BDF, 0, 1);
        run_access("R11 second request", 1'b1, 1'b0, 21'h180000, 32'hFEDC_BA98, 0, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_boot_read();
        t_boot_write();
        t_even_count();
        t_slow_space();
        t_ready_stall();
        t_busy_ignore();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule